// File: doc/BRIEF.md
# Byte-Wide Control Bank with Indirect Sub-Unit Window

This block is the byte-addressed register file that sits behind a serial link and controls a group of hashing sub-units. A front end, not part of this block, turns serial traffic into a parallel address byte, a data byte and one-cycle read and write strobes. The bank decodes them into a set of local control registers and an indirect path into the sub-units. Several addresses are split: a read at such an address returns one register, and a write there reaches a different one.

Local state covers a control byte, a 7-bit chain address, two constant identification bytes and a 32-bit cycle counter. The counter is read out one byte at a time. Reading its low byte freezes the whole count in a snapshot, so that the three upper bytes read afterwards all belong to the same moment.

The sub-units are reached only through a window. Software loads a sub-unit register address and a write-data byte, picks one or more units with a bit-mapped select, and then writes the strobe address. Every selected unit receives the same write in the same cycle. Window reads come from the lowest-numbered selected unit, and only while the read-enable control bit is set.

Top module: `regbank_top`

## Requirements
- R1: A synchronous active-high reset clears every register, the counter and its snapshot, bus_rdata, unit_wr_o and all control outputs to zero.
- R2: Address 0x00 is read/write. It holds the sub-unit register address, which drives unit_addr_o.
- R3: A write to address 0x01 loads the sub-unit write data, which drives unit_wdata_o. A read of 0x01 returns zero.
- R4: A read of address 0x02 returns the sub-unit interrupt inputs, with bit i equal to unit_irq_i[i] and the upper bits zero. A write to 0x02 loads the unit select from the low UNITS bits of the data.
- R5: Address 0x03 is a read/write control byte. Bit 0 drives unit_rd_en_o, bit 2 enables the counter, bit 3 drives led_o, bit 4 drives clkdiv_rst_o and bit 5 drives chain_en_o.
- R6: Address 0x04 holds a 7-bit chain address, written from data bits [6:0]. It drives chip_addr_o and reads back with bit 7 zero.
- R7: A read of 0x05 returns CHIP_ID (default 0x5D). A write to 0x05 raises unit_wr_o, equal to the current select, for exactly the one cycle after the write edge. unit_wr_o is zero at all other times.
- R8: A read of address 0x06 returns UNIT_ID (default 0x3C).
- R9: The counter adds one on each clock edge at which control bit 2 is set, and holds otherwise. A read of 0x07 returns count bits [7:0] and copies all 32 bits into a snapshot. Reads of 0x08, 0x09 and 0x0A return snapshot bits [15:8], [23:16] and [31:24].
- R10: A read of 0x80 returns the unit_rdata_i byte of the lowest-numbered selected unit while control bit 0 is set. With that bit clear, or with no unit selected, it returns zero.
- R11: A read of any other address returns zero. A write to any address other than 0x00 to 0x05 changes nothing.
- R12: bus_rdata changes only on the clock edge that samples bus_rd, which makes the data valid in the following cycle. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_rdata | output | 8 | Registered read data |
| unit_addr_o | output | 8 | Sub-unit register address |
| unit_wdata_o | output | 8 | Sub-unit write data |
| unit_wr_o | output | UNITS | Per-unit write strobe |
| unit_rdata_i | input | 8*UNITS | Read data from each sub-unit |
| unit_irq_i | input | UNITS | Interrupt from each sub-unit |
| unit_rd_en_o | output | 1 | Sub-unit read enable (control bit 0) |
| led_o | output | 1 | LED drive (control bit 3) |
| clkdiv_rst_o | output | 1 | Divided-clock reset (control bit 4) |
| chain_en_o | output | 1 | Chain enable (control bit 5) |
| chip_addr_o | output | 7 | Chain address |

## Verification
Some properties are checked by assertions on every cycle. The counter steps by exactly one or holds, depending on its enable. The unit pick is never more than one-hot. A strobe only follows a write to 0x05. The read data moves only after a read. Window reads with read-enable clear give zero, and the chain address always reads back with bit 7 clear.

Other behaviour only the bench scenarios can show. These cover the split-address pairs, broadcast strobes under all sixteen selects, the lowest-unit priority of the window, the snapshot holding steady while the live count crosses a byte boundary, and a full 256-address sweep showing that stray writes leave every register untouched.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  typedef logic [7:0] addr_t;

  localparam addr_t A_UADDR  = 8'h00;
  localparam addr_t A_UWDATA = 8'h01;
  localparam addr_t A_IRQSEL = 8'h02;
  localparam addr_t A_CTRL   = 8'h03;
  localparam addr_t A_CHIP   = 8'h04;
  localparam addr_t A_IDSTB  = 8'h05;
  localparam addr_t A_UID    = 8'h06;
  localparam addr_t A_CNT0   = 8'h07;
  localparam addr_t A_WIN    = 8'h80;

  localparam int CB_RDEN   = 0;
  localparam int CB_CNTEN  = 2;
  localparam int CB_LED    = 3;
  localparam int CB_CLKRST = 4;
  localparam int CB_CHAIN  = 5;

  localparam int CHIP_W = 7;
endpackage

// File: rtl/regbank_ctrl_regs.sv
module regbank_ctrl_regs
  import regbank_pkg::*;
#(
  parameter int DW    = 8,
  parameter int UNITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  addr_t             addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     unit_addr,
  output logic [DW-1:0]     unit_wdata,
  output logic [UNITS-1:0]  unit_sel,
  output logic [DW-1:0]     ctrl,
  output logic [CHIP_W-1:0] chip_addr,
  output logic              fire
);
  always_ff @(posedge clk) begin
    if (rst) begin
      unit_addr  <= '0;
      unit_wdata <= '0;
      unit_sel   <= '0;
      ctrl       <= '0;
      chip_addr  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_UADDR:  unit_addr  <= wdata;
        A_UWDATA: unit_wdata <= wdata;
        A_IRQSEL: unit_sel   <= wdata[UNITS-1:0];
        A_CTRL:   ctrl       <= wdata;
        A_CHIP:   chip_addr  <= wdata[CHIP_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb fire = wr_en && (addr == A_IDSTB);

  assert_chip_load_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CHIP) |=> (chip_addr == $past(wdata[CHIP_W-1:0])));

  assert_ctrl_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> $stable(ctrl) && $stable(unit_sel));
endmodule

// File: rtl/regbank_perf_counter.sv
module regbank_perf_counter #(
  parameter int DW    = 8,
  parameter int CNT_W = 32,
  localparam int LANES = CNT_W / DW,
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          snap,
  input  logic [LW-1:0] lane_sel,
  output logic [DW-1:0] lane_data
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (en) count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) shadow <= '0;
    else if (snap) shadow <= count;
  end

  always_comb begin
    if (lane_sel == '0) lane_data = count[DW-1:0];
    else lane_data = shadow[lane_sel*DW +: DW];
  end

  assert_cnt_step_R9: assert property (@(posedge clk) disable iff (rst)
    en |=> (count == $past(count) + 1'b1));

  assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> $stable(count));

  assert_snap_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!snap) |=> $stable(shadow));
endmodule

// File: rtl/regbank_window.sv
module regbank_window #(
  parameter int DW    = 8,
  parameter int UNITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fire,
  input  logic                rd_en,
  input  logic [UNITS-1:0]    unit_sel,
  input  logic [UNITS*DW-1:0] unit_rdata,
  output logic [UNITS-1:0]    unit_wr,
  output logic [DW-1:0]       win_data
);
  logic [UNITS-1:0] pick;
  logic [DW-1:0]    lane [UNITS];

  always_ff @(posedge clk) begin
    if (rst) unit_wr <= '0;
    else if (fire) unit_wr <= unit_sel;
    else unit_wr <= '0;
  end

  always_comb pick = unit_sel & (~unit_sel + 1'b1);

  for (genvar i = 0; i < UNITS; i++) begin : g_lane
    assign lane[i] = pick[i] ? unit_rdata[i*DW +: DW] : '0;
  end

  always_comb begin
    win_data = '0;
    if (rd_en)
      for (int i = 0; i < UNITS; i++) win_data = win_data | lane[i];
  end

  assert_pick_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pick));

  assert_strobe_cause_R7: assert property (@(posedge clk) disable iff (rst)
    (|unit_wr) |-> $past(fire));

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
    ((|unit_wr) && !$past(fire, 2)) |=> (unit_wr == '0) || $past(fire));
endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int          DW      = 8,
  parameter int          UNITS   = 4,
  parameter int          CNT_W   = 32,
  parameter logic [7:0]  CHIP_ID = 8'h5D,
  parameter logic [7:0]  UNIT_ID = 8'h3C
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [7:0]          bus_addr,
  input  logic [7:0]          bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  output logic [7:0]          bus_rdata,
  output logic [7:0]          unit_addr_o,
  output logic [7:0]          unit_wdata_o,
  output logic [UNITS-1:0]    unit_wr_o,
  input  logic [UNITS*8-1:0]  unit_rdata_i,
  input  logic [UNITS-1:0]    unit_irq_i,
  output logic                unit_rd_en_o,
  output logic                led_o,
  output logic                clkdiv_rst_o,
  output logic                chain_en_o,
  output logic [6:0]          chip_addr_o
);
  localparam int    LANES  = CNT_W / DW;
  localparam int    LW     = (LANES > 1) ? $clog2(LANES) : 1;
  localparam addr_t A_CNTN = A_CNT0 + addr_t'(LANES - 1);

  logic [DW-1:0]     ctrl;
  logic [UNITS-1:0]  unit_sel;
  logic [CHIP_W-1:0] chip_addr;
  logic              fire;
  logic [DW-1:0]     win_data;
  logic [DW-1:0]     lane_data;
  logic [LW-1:0]     lane_sel;
  logic              snap;
  logic [7:0]        addr_off;

  regbank_ctrl_regs #(.DW(DW), .UNITS(UNITS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .unit_addr(unit_addr_o), .unit_wdata(unit_wdata_o), .unit_sel(unit_sel),
    .ctrl(ctrl), .chip_addr(chip_addr), .fire(fire)
  );

  always_comb begin
    addr_off = bus_addr - A_CNT0;
    lane_sel = addr_off[LW-1:0];
    snap     = bus_rd && (bus_addr == A_CNT0);
  end

  regbank_perf_counter #(.DW(DW), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(ctrl[CB_CNTEN]), .snap(snap),
    .lane_sel(lane_sel), .lane_data(lane_data)
  );

  regbank_window #(.DW(DW), .UNITS(UNITS)) u_win (
    .clk(clk), .rst(rst), .fire(fire), .rd_en(ctrl[CB_RDEN]),
    .unit_sel(unit_sel), .unit_rdata(unit_rdata_i),
    .unit_wr(unit_wr_o), .win_data(win_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr) inside
        A_UADDR:          bus_rdata <= unit_addr_o;
        A_IRQSEL:         bus_rdata <= DW'(unit_irq_i);
        A_CTRL:           bus_rdata <= ctrl;
        A_CHIP:           bus_rdata <= {1'b0, chip_addr};
        A_IDSTB:          bus_rdata <= CHIP_ID;
        A_UID:            bus_rdata <= UNIT_ID;
        [A_CNT0:A_CNTN]:  bus_rdata <= lane_data;
        A_WIN:            bus_rdata <= win_data;
        default:          bus_rdata <= '0;
      endcase
    end
  end

  always_comb begin
    unit_rd_en_o = ctrl[CB_RDEN];
    led_o        = ctrl[CB_LED];
    clkdiv_rst_o = ctrl[CB_CLKRST];
    chain_en_o   = ctrl[CB_CHAIN];
    chip_addr_o  = chip_addr;
  end

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd) |=> $stable(bus_rdata));

  assert_win_gated_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_WIN && !ctrl[CB_RDEN]) |=> (bus_rdata == '0));

  assert_chip_msb_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_CHIP) |=> (bus_rdata[7] == 1'b0));

  assert_wo_read_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_UWDATA) |=> (bus_rdata == '0));
endmodule

// File: tb/regbank_top_bench.sv
`timescale 1ns/1ps
module regbank_top_bench;
  localparam int UNITS = 4;

  logic clk = 0;
  logic rst = 1;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_rdata, unit_addr_o, unit_wdata_o;
  logic [UNITS-1:0] unit_wr_o, unit_irq_i = 0;
  logic [UNITS*8-1:0] unit_rdata_i;
  logic unit_rd_en_o, led_o, clkdiv_rst_o, chain_en_o;
  logic [6:0] chip_addr_o;

  int errors = 0, checks = 0, strobes_seen = 0;
  bit finished = 0;

  logic [7:0] m_uaddr = 0, m_uwdata = 0, m_ctrl = 0, m_chip = 0;

  always #2.5 clk = ~clk;

  regbank_top u_regbank_top (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .unit_addr_o(unit_addr_o), .unit_wdata_o(unit_wdata_o), .unit_wr_o(unit_wr_o),
    .unit_rdata_i(unit_rdata_i), .unit_irq_i(unit_irq_i),
    .unit_rd_en_o(unit_rd_en_o), .led_o(led_o), .clkdiv_rst_o(clkdiv_rst_o),
    .chain_en_o(chain_en_o), .chip_addr_o(chip_addr_o)
  );

  function automatic logic [7:0] unit_val(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  initial for (int i = 0; i < UNITS; i++) unit_rdata_i[i*8 +: 8] = unit_val(i);

  always @(negedge clk) if (!rst && unit_wr_o != 0) strobes_seen++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  function automatic logic [7:0] exp_read(logic [7:0] a);
    case (a)
      8'h00: return m_uaddr;
      8'h02: return 8'(unit_irq_i);
      8'h03: return m_ctrl;
      8'h04: return m_chip & 8'h7F;
      8'h05: return 8'h5D;
      8'h06: return 8'h3C;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", bus_rdata, 0);
    check("R1 outputs", {unit_addr_o, unit_wdata_o, unit_wr_o, unit_rd_en_o, led_o,
          clkdiv_rst_o, chain_en_o, chip_addr_o}, 0);
    bread(8'h03, d); check("R1 ctrl", d, 0);
    bread(8'h07, d); check("R1 count", d, 0);

    // R9 counter: enabled across K+2 edges
    bwrite(8'h03, 8'h04);
    repeat (252) @(negedge clk);
    bwrite(8'h03, 8'h00);
    bread(8'h07, d); check("R9 count lo", d, 8'hFE);
    bread(8'h08, d); check("R9 count b1", d, 8'h00);
    bwrite(8'h03, 8'h04);
    bread(8'h07, d); check("R9 running lo", d, 8'hFF);
    repeat (10) @(negedge clk);
    bread(8'h08, d); check("R9 snapshot b1", d, 8'h00);
    bread(8'h09, d); check("R9 snapshot b2", d, 8'h00);
    bread(8'h0A, d); check("R9 snapshot b3", d, 8'h00);
    bread(8'h07, d);
    bread(8'h08, d2); check("R9 new snapshot b1", d2, 8'h01);
    bwrite(8'h03, 8'h00);

    // R12 read data holds
    bread(8'h06, d);
    repeat (5) @(negedge clk);
    check("R12 hold", bus_rdata, 8'h3C);

    // R2 / R3 sweeps
    for (int v = 0; v < 256; v++) begin
      bwrite(8'h00, 8'(v)); m_uaddr = 8'(v);
      bread(8'h00, d); check("R2 readback", d, m_uaddr);
      check("R2 port", unit_addr_o, m_uaddr);
      bwrite(8'h01, 8'(255 - v)); m_uwdata = 8'(255 - v);
      check("R3 port", unit_wdata_o, m_uwdata);
      bread(8'h01, d); check("R3 read zero", d, 0);
    end

    // R5 control sweep
    for (int v = 0; v < 256; v++) begin
      bwrite(8'h03, 8'(v)); m_ctrl = 8'(v);
      bread(8'h03, d); check("R5 readback", d, m_ctrl);
      check("R5 pins", {chain_en_o, clkdiv_rst_o, led_o, unit_rd_en_o},
            {m_ctrl[5], m_ctrl[4], m_ctrl[3], m_ctrl[0]});
    end
    bwrite(8'h03, 8'h00); m_ctrl = 0;

    // R6 chain address sweep
    for (int v = 0; v < 256; v++) begin
      bwrite(8'h04, 8'(v)); m_chip = 8'(v);
      bread(8'h04, d); check("R6 readback", d, m_chip & 8'h7F);
      check("R6 port", chip_addr_o, m_chip[6:0]);
    end

    // R4 interrupt status
    for (int v = 0; v < 16; v++) begin
      unit_irq_i = 4'(v);
      bread(8'h02, d); check("R4 irq", d, 8'(v));
    end

    // R7 broadcast strobe
    strobes_seen = 0;
    for (int s = 0; s < 16; s++) begin
      bwrite(8'h02, 8'(s));
      bwrite(8'h00, 8'(s + 8'h40)); m_uaddr = 8'(s + 8'h40);
      bwrite(8'h01, 8'(s * 3)); m_uwdata = 8'(s * 3);
      @(negedge clk); bus_addr = 8'h05; bus_wdata = 8'hAA; bus_wr = 1;
      @(negedge clk); bus_wr = 0;
      check("R7 strobe", {unit_wr_o, unit_addr_o, unit_wdata_o}, {4'(s), m_uaddr, m_uwdata});
      @(negedge clk);
      check("R7 strobe ends", unit_wr_o, 0);
    end
    check("R7 strobe count", strobes_seen, 15);
    bread(8'h05, d); check("R7 chip id", d, 8'h5D);
    bread(8'h06, d); check("R8 unit id", d, 8'h3C);

    // R10 window priority
    for (int en = 0; en < 2; en++) begin
      bwrite(8'h03, 8'(en)); m_ctrl = 8'(en);
      for (int s = 0; s < 16; s++) begin
        logic [7:0] e;
        bwrite(8'h02, 8'(s));
        e = 0;
        if (en == 1)
          for (int i = UNITS - 1; i >= 0; i--) if (s[i]) e = unit_val(i);
        bread(8'h80, d); check("R10 window", d, e);
      end
    end

    // R11 stray writes ignored, full read sweep
    for (int a = 6; a < 256; a++) bwrite(8'(a), 8'hFF);
    check("R11 no strobe", strobes_seen, 15);
    for (int a = 0; a < 256; a++) begin
      if (a >= 7 && a <= 10) continue;
      if (a == 8'h80) continue;
      bread(8'(a), d); check("R11 sweep", d, exp_read(8'(a)));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule